// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block sits on the host side of a parallel flash device. It writes a run of consecutive bytes into the device over a chip-select, read-strobe, write-strobe, address and data interface. The bytes arrive one at a time from a request/valid source port. For each byte the sequencer runs a closed loop. It sends a program-setup command, then an address/data write. It waits a fixed program time, then sends a verify command and waits for the read recovery time. It then reads the byte back and compares it with the byte it meant to write. On a mismatch it applies another pulse. Once a byte has had the largest allowed number of pulses, the run is declared failed.

Software starts a run with a one-cycle `start` pulse, a base address and a byte count. While the run is active the sequencer raises a request for the programming voltage. A run ends in one of two ways: the last byte verifies, or a byte fails. In both cases the sequencer writes the read-array command and releases the voltage request. Only after that does it pulse `done`, with `fail` showing the outcome. The program wait, the verify wait, the strobe widths and the pulse limit are parameters.

Top module: `fpgm_seq`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe`, `vpp_req`, `src_req`, `done` and `fail` are low.
- R2: Every address/data program write to the device comes directly after a write of the program-setup command 40H.
- R3: The verify command C0H is written only after a program write, and at least PROG_CYC clock cycles after the rising write strobe of that program write.
- R4: Each read strobe (`fl_oe_n` falling) comes at least VER_CYC cycles after the last rising write strobe. It happens only while the device is in verify mode, and the data bus is never driven while `fl_oe_n` is low.
- R5: The pulse count starts at zero for every byte. A byte that needs k pulses with k <= MAX_PULSES gets exactly k program writes. A byte that never verifies gets exactly MAX_PULSES program writes, and then the run ends with `fail` high.
- R6: A byte that verifies makes the sequencer advance the address by one, wrapping modulo 2^AW. It then requests exactly one new source byte, so byte i of the stream lands at base address + i.
- R7: At the end of every run, exactly one read-array command 00H is written. It is the last device write, and `vpp_req` is low when the one-cycle `done` pulse appears with `fail` valid.
- R8: After a failed byte, no further source byte is requested and no later address receives a program write.
- R9: A byte count of zero requests no source byte and programs nothing. It writes 00H once and ends with `done` and `fail` low.
- R10: `fl_we_n` is low only while `fl_ce_n` is low and `vpp_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run (taken when idle) |
| base_addr | input | AW | First device address of the run |
| byte_cnt | input | CW | Number of bytes to program |
| src_req | output | 1 | Requests the next source byte |
| src_valid | input | 1 | Source byte is present; taken when `src_req` is also high |
| src_data | input | DW | Source byte |
| fl_ce_n | output | 1 | Device chip select, active low |
| fl_oe_n | output | 1 | Device read strobe, active low |
| fl_we_n | output | 1 | Device write strobe, active low |
| fl_addr | output | AW | Device address |
| fl_dq_o | output | DW | Data driven toward the device |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_i | input | DW | Data read from the device |
| vpp_req | output | 1 | Request for the programming voltage |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run failed; valid with `done`, held until the next start |

## Verification
The bench builds the block with AW=4, a 5-bit count, MAX_PULSES=3, PROG_CYC=8, VER_CYC=5 and two-cycle strobes. With these values a 16-byte device model is covered, including runs that wrap past the top address. The model's per-address pulse requirement goes from one pulse up to past the limit, so retries, the exact limit and the failure path all occur across a sweep of every base address. Zero-length and full-length runs cover the count extremes, and the short waits let the spacing rules be checked at cycle granularity.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_PROG, S_PWAIT,
    S_VCMD, S_VWAIT, S_VREAD, S_CMP, S_RDCMD, S_REL
  } seq_st_t;

  typedef enum logic [2:0] {
    B_IDLE, B_SET, B_STRB, B_HOLD, B_RD
  } bus_st_t;

  localparam logic [7:0] OP_PGM_SETUP  = 8'h40;
  localparam logic [7:0] OP_PGM_VERIFY = 8'hC0;
  localparam logic [7:0] OP_READ_ARRAY = 8'h00;

endpackage

// File: rtl/fpgm_wait.sv
module fpgm_wait #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          fire
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt <= val;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == TW'(1)) fire <= 1'b1;
      end
    end
  end

  AST_FIRE_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(cnt) == TW'(1)); // R3

endmodule

// File: rtl/fpgm_buscyc.sv
module fpgm_buscyc
  import fpgm_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int WE_CYC = 15,
  parameter int RD_CYC = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          is_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] a_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata,
  output logic          op_done
);

  localparam int CMAX = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CNW  = $clog2(CMAX + 1);

  bus_st_t        st;
  logic [CNW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= B_IDLE;
      cnt     <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      a_o     <= '0;
      dq_o    <= '0;
      rdata   <= '0;
      op_done <= 1'b0;
    end else begin
      op_done <= 1'b0;
      unique case (st)
        B_IDLE: if (go) begin
          a_o  <= addr;
          dq_o <= wdata;
          ce_n <= 1'b0;
          cnt  <= '0;
          if (is_rd) begin
            oe_n <= 1'b0;
            st   <= B_RD;
          end else begin
            dq_oe <= 1'b1;
            st    <= B_SET;
          end
        end
        B_SET: begin
          we_n <= 1'b0;
          cnt  <= '0;
          st   <= B_STRB;
        end
        B_STRB: begin
          if (cnt == CNW'(WE_CYC - 1)) begin
            we_n <= 1'b1;
            st   <= B_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        B_HOLD: begin
          ce_n    <= 1'b1;
          dq_oe   <= 1'b0;
          op_done <= 1'b1;
          st      <= B_IDLE;
        end
        B_RD: begin
          if (cnt == CNW'(RD_CYC - 1)) begin
            rdata   <= dq_i;
            oe_n    <= 1'b1;
            ce_n    <= 1'b1;
            op_done <= 1'b1;
            st      <= B_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n); // R10

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe); // R4

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n)); // R4

endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
  import fpgm_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int CW         = 17,
  parameter int MAX_PULSES = 25,
  parameter int PROG_CYC   = 2500,
  parameter int VER_CYC    = 1500,
  parameter int WE_CYC     = 15,
  parameter int RD_CYC     = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_cnt,
  output logic          src_req,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          vpp_req,
  output logic          done,
  output logic          fail
);

  localparam int TMAX = (PROG_CYC > VER_CYC) ? PROG_CYC : VER_CYC;
  localparam int TW   = $clog2(TMAX + 2);
  localparam int PCW  = $clog2(MAX_PULSES + 1);

  seq_st_t        st;
  logic [AW-1:0]  cur_addr;
  logic [CW-1:0]  left;
  logic [DW-1:0]  exp_d;
  logic [PCW-1:0] pcnt;
  logic           err;

  logic           bus_go, bus_rd, bus_done;
  logic [AW-1:0]  bus_a;
  logic [DW-1:0]  bus_d, bus_rdata;
  logic           tmr_load, tmr_fire;
  logic [TW-1:0]  tmr_val;

  fpgm_buscyc #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_bus (
    .clk(clk), .rst(rst), .go(bus_go), .is_rd(bus_rd), .addr(bus_a),
    .wdata(bus_d), .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n),
    .a_o(fl_addr), .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .dq_i(fl_dq_i),
    .rdata(bus_rdata), .op_done(bus_done)
  );

  fpgm_wait #(.TW(TW)) u_wait (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .fire(tmr_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      left     <= '0;
      exp_d    <= '0;
      pcnt     <= '0;
      err      <= 1'b0;
      src_req  <= 1'b0;
      vpp_req  <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      bus_go   <= 1'b0;
      bus_rd   <= 1'b0;
      bus_a    <= '0;
      bus_d    <= '0;
      tmr_load <= 1'b0;
      tmr_val  <= '0;
    end else begin
      bus_go   <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          cur_addr <= base_addr;
          left     <= byte_cnt;
          err      <= 1'b0;
          fail     <= 1'b0;
          vpp_req  <= 1'b1;
          if (byte_cnt == '0) begin
            bus_go <= 1'b1;
            bus_rd <= 1'b0;
            bus_a  <= base_addr;
            bus_d  <= DW'(OP_READ_ARRAY);
            st     <= S_RDCMD;
          end else begin
            src_req <= 1'b1;
            st      <= S_FETCH;
          end
        end
        S_FETCH: if (src_valid) begin
          exp_d   <= src_data;
          src_req <= 1'b0;
          pcnt    <= '0;
          bus_go  <= 1'b1;
          bus_rd  <= 1'b0;
          bus_a   <= cur_addr;
          bus_d   <= DW'(OP_PGM_SETUP);
          st      <= S_SETUP;
        end
        S_SETUP: if (bus_done) begin
          bus_go <= 1'b1;
          bus_rd <= 1'b0;
          bus_a  <= cur_addr;
          bus_d  <= exp_d;
          st     <= S_PROG;
        end
        S_PROG: if (bus_done) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(PROG_CYC);
          st       <= S_PWAIT;
        end
        S_PWAIT: if (tmr_fire) begin
          bus_go <= 1'b1;
          bus_rd <= 1'b0;
          bus_a  <= cur_addr;
          bus_d  <= DW'(OP_PGM_VERIFY);
          st     <= S_VCMD;
        end
        S_VCMD: if (bus_done) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(VER_CYC);
          st       <= S_VWAIT;
        end
        S_VWAIT: if (tmr_fire) begin
          bus_go <= 1'b1;
          bus_rd <= 1'b1;
          bus_a  <= cur_addr;
          st     <= S_VREAD;
        end
        S_VREAD: if (bus_done) st <= S_CMP;
        S_CMP: begin
          bus_rd <= 1'b0;
          bus_a  <= cur_addr;
          if (bus_rdata == exp_d) begin
            if (left == CW'(1)) begin
              bus_go <= 1'b1;
              bus_d  <= DW'(OP_READ_ARRAY);
              st     <= S_RDCMD;
            end else begin
              cur_addr <= cur_addr + 1'b1;
              left     <= left - 1'b1;
              src_req  <= 1'b1;
              st       <= S_FETCH;
            end
          end else if (pcnt == PCW'(MAX_PULSES - 1)) begin
            err    <= 1'b1;
            bus_go <= 1'b1;
            bus_d  <= DW'(OP_READ_ARRAY);
            st     <= S_RDCMD;
          end else begin
            pcnt   <= pcnt + 1'b1;
            bus_go <= 1'b1;
            bus_d  <= DW'(OP_PGM_SETUP);
            st     <= S_SETUP;
          end
        end
        S_RDCMD: if (bus_done) begin
          vpp_req <= 1'b0;
          st      <= S_REL;
        end
        S_REL: begin
          done <= 1'b1;
          fail <= err;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // cycles since the last rising write strobe, saturating
  logic [TW-1:0] wr_gap;
  logic          we_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_gap <= '1;
      we_q   <= 1'b1;
    end else begin
      we_q <= fl_we_n;
      if (!we_q && fl_we_n)  wr_gap <= '0;
      else if (wr_gap != '1) wr_gap <= wr_gap + 1'b1;
    end
  end

  AST_READ_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_oe_n) |-> wr_gap >= TW'(VER_CYC)); // R4

  AST_VPP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> vpp_req); // R10

  AST_DONE_VPP_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> !vpp_req && fl_ce_n); // R7

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PCW'(MAX_PULSES - 1)); // R5

  AST_SRC_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
    src_req |-> vpp_req && !err); // R8

endmodule

// File: tb/tb_fpgm_seq.sv
module tb_fpgm_seq;

  localparam int AW = 4, DW = 8, CW = 5, MAXP = 3;
  localparam int PROG_CYC = 8, VER_CYC = 5;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic src_req, src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, vpp_req, done, fail;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;

  always #2 clk = ~clk;

  fpgm_seq #(.AW(AW), .DW(DW), .CW(CW), .MAX_PULSES(MAXP),
             .PROG_CYC(PROG_CYC), .VER_CYC(VER_CYC), .WE_CYC(2), .RD_CYC(2)) dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .byte_cnt(byte_cnt),
    .src_req(src_req), .src_valid(src_valid), .src_data(src_data),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .vpp_req(vpp_req), .done(done), .fail(fail)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model, evaluated on the falling edge
  logic [7:0] mem [NB];
  int need [NB];
  int pulses [NB];
  int md = 0;               // 0 read, 1 setup seen, 2 verify, 3 programmed
  logic [AW-1:0] plat = '0;
  int cyc = 0, last_rise = -1000, last_prog = -1000;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int e_setup = 0, e_pwait = 0, e_rd = 0, e_vpp = 0, n_rdcmd = 0, wr_after_rd = 0;
  int fetch_n = 0, salt = 0;
  int cur_base = 0;

  function automatic logic [7:0] dat(input int a, input int s);
    return 8'((a * 29 + s * 7 + 3)) & 8'hFE;
  endfunction

  always_comb fl_dq_i = (md == 2) ? mem[plat] : mem[fl_addr];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!fl_we_n && (!vpp_req || fl_ce_n)) e_vpp++;
      if (!fl_oe_n && fl_dq_oe) e_rd++;
      if (prev_oe && !fl_oe_n) begin
        if (cyc - last_rise < VER_CYC) e_rd++;
        if (md != 2) e_rd++;
      end
      if (!prev_we && fl_we_n && !fl_ce_n) begin
        last_rise = cyc;
        if (n_rdcmd != 0) wr_after_rd++;
        if (md == 1) begin
          pulses[fl_addr]++;
          if (pulses[fl_addr] >= need[fl_addr]) mem[fl_addr] = fl_dq_o;
          plat = fl_addr;
          md = 3;
          last_prog = cyc;
        end else begin
          case (fl_dq_o)
            8'h40: md = 1;
            8'hC0: begin
              if (md != 3 || cyc - last_prog < PROG_CYC) e_pwait++;
              md = 2;
            end
            8'h00: begin md = 0; n_rdcmd++; end
            default: e_setup++;
          endcase
        end
      end
      // a program write without a preceding setup would be decoded as an unknown command
      if (src_req && !src_valid) begin
        src_valid = 1'b1;
        src_data  = dat((cur_base + fetch_n) % NB, salt);
        fetch_n++;
      end else if (!src_req) begin
        src_valid = 1'b0;
      end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  bit timed_out = 0;

  task automatic run(input int base, input int cnt, input int s);
    int exp_fail_at, exp_fetch, wait_n;
    bit got_done, exp_fail;
    salt = s;
    cur_base = base;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; pulses[i] = 0; end
    fetch_n = 0; n_rdcmd = 0; wr_after_rd = 0;
    e_setup = 0; e_pwait = 0; e_rd = 0; e_vpp = 0;
    // expected outcome from the requirements
    exp_fail_at = -1;
    for (int k = 0; k < cnt; k++)
      if (exp_fail_at < 0 && need[(base + k) % NB] > MAXP) exp_fail_at = k;
    exp_fail  = (exp_fail_at >= 0);
    exp_fetch = exp_fail ? exp_fail_at + 1 : cnt;
    @(negedge clk);
    base_addr = AW'(base);
    byte_cnt  = CW'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    got_done  = 0;
    wait_n    = 0;
    while (!got_done && wait_n < 20000) begin
      if (done) got_done = 1;
      else begin @(negedge clk); wait_n++; end
    end
    check(got_done, "R7 done seen", int'(got_done), 1);
    if (!got_done) begin timed_out = 1; return; end
    check(fail == exp_fail, cnt == 0 ? "R9 fail flag" : "R5 fail flag", int'(fail), int'(exp_fail));
    check(!vpp_req, "R7 vpp released at done", int'(vpp_req), 0);
    check(n_rdcmd == 1 && wr_after_rd == 0, "R7 single final 00H", n_rdcmd, 1);
    check(e_setup == 0, "R2 setup before program", e_setup, 0);
    check(e_pwait == 0, "R3 program wait before verify", e_pwait, 0);
    check(e_rd == 0, "R4 read recovery and bus", e_rd, 0);
    check(e_vpp == 0, "R10 write strobe conditions", e_vpp, 0);
    check(fetch_n == exp_fetch, exp_fail ? "R8 fetch count" : "R6 fetch count", fetch_n, exp_fetch);
    for (int i = 0; i < NB; i++) begin
      int k, ep;
      logic [7:0] em;
      k  = (i - base + NB) % NB;
      ep = 0;
      em = 8'hFF;
      if (cnt >= NB || k < exp_fetch) begin
        ep = (need[i] > MAXP) ? MAXP : need[i];
        if (need[i] <= MAXP) em = dat(i, s);
      end
      if (cnt == 0) ep = 0;
      check(pulses[i] == ep, (k >= exp_fetch) ? "R8 pulses" : "R5 pulses", pulses[i], ep);
      check(mem[i] == em, "R6 data placement", int'(mem[i]), int'(em));
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin need[i] = 1; mem[i] = 8'hFF; pulses[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 strobes idle",
          int'({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}), 14);
    check(!vpp_req && !src_req && !done && !fail, "R1 flags low",
          int'({vpp_req, src_req, done, fail}), 0);

    run(2, 4, 1);                                   // R6 plain run
    run(0, 0, 2);                                   // R9 empty run
    for (int i = 0; i < NB; i++) need[i] = (i % 3) + 1;
    run(0, 16, 3);                                  // R5 retries up to the limit
    for (int b = 0; b < NB && !timed_out; b++) begin
      for (int i = 0; i < NB; i++) need[i] = ((i + b) % 5) + 1;
      run(b, (b % 6) + 1, b + 4);                   // R5 R8 sweep with wrap
    end
    for (int i = 0; i < NB; i++) need[i] = 2;
    if (!timed_out) run(13, 6, 9);                  // R6 wrap past top
    if (!timed_out) run(7, 0, 10);                  // R9 empty at other base

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule